// File: doc/BRIEF.md
# Tick-Counter Real-Time Clock with Compare Alarms

The block keeps time for a chip from a 32768 Hz oscillator. A programmable prescaler turns the oscillator into a slow tick, and each tick advances a 32-bit binary counter. With the reset divider of 1023 the counter steps at 16 Hz, so its four low bits count sixteenths of a second and the upper bits count seconds. Software may write the counter at any time, and the counter wraps from all-ones to zero.

Three event sources feed sticky flags in one status word: two compare alarms, each of which fires when the counter becomes equal to its alarm register, and the tick itself. Each flag has its own enable. The interrupt and wake outputs are high while any enabled flag is set. Flags are cleared by writing a one to them. Enables hold whatever value is written. A scratch register gives software a place to keep the wrap (epoch) count, which extends the counter into a full time value. A two-bit clock-select field must hold code 3 for time to advance.

Access is through a plain single-cycle register bus. Reads return data one cycle later, captured in the same clock domain as the counter, so a counter read is never torn.

Top module: `rtc_tick_timer`

## Requirements
- R1: After reset the counter, both alarms, the status word and the scratch register read 0, the divider reads 1023, the clock select reads 3, and irq and wake are low.
- R2: While the clock select holds 3, a tick occurs every 2*(DIV+1) clock cycles and each tick adds one to the counter. The prescaler restarts from zero when the divider is written or when counting resumes.
- R3: An alarm flag sets in the cycle after the counter becomes equal to that alarm register, whether by a tick or by a write of the counter. It does not set again while that equality merely persists.
- R4: Status bits 0 (alarm0 flag), 1 (tick flag) and 4 (alarm1 flag) are write-one-to-clear. Writing 0 leaves a flag unchanged, and an event in the same cycle as a clear leaves the flag set.
- R5: Status bits 2 (alarm0 enable), 3 (tick enable) and 6 (alarm1 enable) take the value written. Every other status bit reads 0.
- R6: The registers are read/write at these byte offsets: counter 0x00, alarm0 0x04, status 0x08, divider 0x0C (16 bits), alarm1 0x18, clock select 0x1C (2 bits) and scratch 0x40. Unmapped offsets, including 0x14, read 0 and ignore writes.
- R7: irq and wake go high one cycle after any flag and its enable are both 1, and go low one cycle after no such pair remains.
- R8: With any clock-select code other than 3, no tick occurs and the counter holds its value.
- R9: The counter wraps from 0xFFFFFFFF to 0x00000000 on a tick.
- R10: Writing an alarm register with a value that differs from the counter sets no flag. Writing it with a value equal to the counter, including 0 against a zero counter, sets the flag.
- R11: The tick flag sets on every counter increment, whether or not the tick enable is 1.
- R12: A read presents the register value on bus_rdata at the clock edge that samples bus_rd, and bus_rdata holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32768 Hz oscillator clock, also the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt: any enabled flag set |
| wake | output | 1 | Wake request, same condition as irq |

## Verification
Register access is first walked with distinct bit patterns at every offset, so that a crossed decode, a truncated field or a write to an unmapped slot shows up as a wrong read-back. Counting is then tried at a small divider, with the counter read after an exact number of tick periods. That run separates a wrong period from a missed increment. The same run is also made under a reserved clock code, to show the counter holds. Alarms are tried in three cases: a value unequal to the counter, a value reached by the wrap from all-ones, and a zero written against a zero counter. Together these tell a spurious fire from a missed match. The status word is exercised with one-writes, zero-writes and enable changes alone, which separates write-one-to-clear from plain storage and shows that irq follows the enable gating.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;
  // Byte offsets on the register bus
  localparam logic [7:0] OFF_COUNT  = 8'h00;
  localparam logic [7:0] OFF_ALM0   = 8'h04;
  localparam logic [7:0] OFF_STATUS = 8'h08;
  localparam logic [7:0] OFF_DIV    = 8'h0C;
  localparam logic [7:0] OFF_ALM1   = 8'h18;
  localparam logic [7:0] OFF_CLKSEL = 8'h1C;
  localparam logic [7:0] OFF_SCRAT  = 8'h40;

  // Event sources, index into flag/enable vectors
  localparam int EV_ALM0 = 0;
  localparam int EV_TICK = 1;
  localparam int EV_ALM1 = 2;
  localparam int N_EV    = 3;
  localparam int N_ALARM = 2;

  localparam logic [1:0] CLKSEL_RUN = 2'b11;

  // Status word layout: flags at 0,1,4 and enables at 2,3,6
  function automatic logic [N_EV-1:0] flag_field(input logic [31:0] w);
    return {w[4], w[1], w[0]};
  endfunction

  function automatic logic [N_EV-1:0] en_field(input logic [31:0] w);
    return {w[6], w[3], w[2]};
  endfunction

  function automatic logic [31:0] pack_status(input logic [N_EV-1:0] fl,
                                              input logic [N_EV-1:0] en);
    logic [31:0] w;
    w    = '0;
    w[0] = fl[EV_ALM0];
    w[1] = fl[EV_TICK];
    w[2] = en[EV_ALM0];
    w[3] = en[EV_TICK];
    w[4] = fl[EV_ALM1];
    w[6] = en[EV_ALM1];
    return w;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int PC_W = DIV_W + 1;

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] last_val;

  // Period is 2*(div+1) cycles: count 0 .. 2*div+1
  assign last_val = {div, 1'b1};
  assign tick     = run && (pc_q == last_val);

  always_ff @(posedge clk) begin
    if (rst || !run || restart) begin
      pc_q <= '0;
    end else if (tick) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             tick,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (wr) begin
      count <= wdata;
    end else if (tick) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] alarm_q,
  output logic             hit
);
  logic match;
  logic seen_q;

  assign match = (count == alarm_q);
  // Fire only when equality is new; a rewrite of either side re-arms
  assign hit   = match && !seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_q <= '0;
      seen_q  <= 1'b1;
    end else begin
      if (wr) begin
        alarm_q <= wdata;
      end
      if (wr || cnt_wr) begin
        seen_q <= 1'b0;
      end else begin
        seen_q <= match;
      end
    end
  end
endmodule

// File: rtl/rtc_status.sv
module rtc_status #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en_in,
  input  logic [N-1:0] events,
  output logic [N-1:0] flags,
  output logic [N-1:0] enables,
  output logic         irq_q
);
  logic [N-1:0] clr_mask;

  assign clr_mask = wr ? clr : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags   <= '0;
      enables <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags <= (flags & ~clr_mask) | events;
      if (wr) begin
        enables <= en_in;
      end
      irq_q <= |(flags & enables);
    end
  end
endmodule

// File: rtl/rtc_tick_timer.sv
module rtc_tick_timer #(
  parameter int          CNT_W     = 32,
  parameter int          DIV_W     = 16,
  parameter int          ADDR_W    = 8,
  parameter int unsigned DIV_RESET = 1023
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq,
  output logic              wake
);
  import rtc_tick_pkg::*;

  logic [7:0]       off;
  logic             cnt_wr, stat_wr, div_wr, sel_wr, scr_wr;
  logic [N_ALARM-1:0] alm_wr;
  logic [DIV_W-1:0] div_q;
  logic [1:0]       clk_sel_q;
  logic [CNT_W-1:0] scratch_q;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] alarm_val [N_ALARM];
  logic [N_ALARM-1:0] alarm_hit;
  logic             tick;
  logic             run;
  logic [N_EV-1:0]  events;
  logic [N_EV-1:0]  flags;
  logic [N_EV-1:0]  enables;
  logic             irq_q;
  logic [31:0]      status_word;
  logic [CNT_W-1:0] rd_mux;

  assign off     = 8'(bus_addr);
  assign cnt_wr  = bus_wr && (off == OFF_COUNT);
  assign stat_wr = bus_wr && (off == OFF_STATUS);
  assign div_wr  = bus_wr && (off == OFF_DIV);
  assign sel_wr  = bus_wr && (off == OFF_CLKSEL);
  assign scr_wr  = bus_wr && (off == OFF_SCRAT);
  assign alm_wr[0] = bus_wr && (off == OFF_ALM0);
  assign alm_wr[1] = bus_wr && (off == OFF_ALM1);
  assign run     = (clk_sel_q == CLKSEL_RUN);

  // Plain configuration and scratch storage
  always_ff @(posedge clk) begin
    if (rst) begin
      div_q     <= DIV_W'(DIV_RESET);
      clk_sel_q <= CLKSEL_RUN;
      scratch_q <= '0;
    end else begin
      if (div_wr) div_q     <= bus_wdata[DIV_W-1:0];
      if (sel_wr) clk_sel_q <= bus_wdata[1:0];
      if (scr_wr) scratch_q <= bus_wdata;
    end
  end

  rtc_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .restart (div_wr),
    .div     (div_q),
    .tick    (tick)
  );

  rtc_counter #(.CNT_W(CNT_W)) u_count (
    .clk   (clk),
    .rst   (rst),
    .wr    (cnt_wr),
    .wdata (bus_wdata),
    .tick  (tick),
    .count (count_q)
  );

  for (genvar g = 0; g < N_ALARM; g++) begin : g_alarm
    rtc_alarm_cmp #(.CNT_W(CNT_W)) u_cmp (
      .clk     (clk),
      .rst     (rst),
      .wr      (alm_wr[g]),
      .wdata   (bus_wdata),
      .cnt_wr  (cnt_wr),
      .count   (count_q),
      .alarm_q (alarm_val[g]),
      .hit     (alarm_hit[g])
    );
  end

  assign events[EV_ALM0] = alarm_hit[0];
  assign events[EV_TICK] = tick;
  assign events[EV_ALM1] = alarm_hit[1];

  rtc_status #(.N(N_EV)) u_stat (
    .clk     (clk),
    .rst     (rst),
    .wr      (stat_wr),
    .clr     (flag_field(32'(bus_wdata))),
    .en_in   (en_field(32'(bus_wdata))),
    .events  (events),
    .flags   (flags),
    .enables (enables),
    .irq_q   (irq_q)
  );

  assign status_word = pack_status(flags, enables);
  assign irq  = irq_q;
  assign wake = irq_q;

  always_comb begin
    rd_mux = '0;
    case (off)
      OFF_COUNT:  rd_mux = count_q;
      OFF_ALM0:   rd_mux = alarm_val[0];
      OFF_ALM1:   rd_mux = alarm_val[1];
      OFF_STATUS: rd_mux = CNT_W'(status_word);
      OFF_DIV:    rd_mux = CNT_W'(div_q);
      OFF_CLKSEL: rd_mux = CNT_W'(clk_sel_q);
      OFF_SCRAT:  rd_mux = scratch_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/rtc_tick_timer_chk.sv
module rtc_tick_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] count,
  input logic [2:0]       flags,
  input logic [2:0]       enables,
  input logic [2:0]       events,
  input logic [1:0]       clk_sel,
  input logic             stat_wr,
  input logic [CNT_W-1:0] wdata,
  input logic             irq,
  input logic             wake
);
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_wr) |=> (count == $past(count) + 1'b1));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (clk_sel != 2'b11) |-> !tick);

  p_hold_cnt_r8: assert property (@(posedge clk) disable iff (rst)
    (!tick && !cnt_wr) |=> $stable(count));

  p_alarm_set_r3: assert property (@(posedge clk) disable iff (rst)
    events[0] |=> flags[0]);

  p_tick_set_r11: assert property (@(posedge clk) disable iff (rst)
    tick |=> flags[1]);

  p_w1c_r4: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && wdata[0] && !events[0]) |=> !flags[0]);

  p_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (flags[2] && !(stat_wr && wdata[4])) |=> flags[2]);

  p_en_load_r5: assert property (@(posedge clk) disable iff (rst)
    stat_wr |=> (enables == $past({wdata[6], wdata[3], wdata[2]})));

  p_irq_on_r7: assert property (@(posedge clk) disable iff (rst)
    (|(flags & enables)) |=> irq);

  p_irq_off_r7: assert property (@(posedge clk) disable iff (rst)
    !(|(flags & enables)) |=> !irq);

  p_wake_r7: assert property (@(posedge clk) disable iff (rst)
    irq == wake);
endmodule

bind rtc_tick_timer rtc_tick_timer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk     (clk),
  .rst     (rst),
  .tick    (tick),
  .cnt_wr  (cnt_wr),
  .count   (count_q),
  .flags   (flags),
  .enables (enables),
  .events  (events),
  .clk_sel (clk_sel_q),
  .stat_wr (stat_wr),
  .wdata   (bus_wdata),
  .irq     (irq),
  .wake    (wake)
);

// File: tb/test_rtc_tick_timer.sv
module test_rtc_tick_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int NV         = 6;

  // Register walk: offset, value written, value expected back
  localparam logic [7:0]  V_ADDR [NV] = '{8'h40, 8'h04, 8'h18, 8'h0C, 8'h1C, 8'h14};
  localparam logic [31:0] V_WR   [NV] = '{32'hA5A5_5A5A, 32'h1234_5678, 32'h0F0F_F0F0,
                                          32'hABCD_0001, 32'h0000_0006, 32'hFFFF_FFFF};
  localparam logic [31:0] V_EXP  [NV] = '{32'hA5A5_5A5A, 32'h1234_5678, 32'h0F0F_F0F0,
                                          32'h0000_0001, 32'h0000_0002, 32'h0000_0000};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, wake;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_tick_timer i_rtc_tick_timer (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .wake(wake)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    logic [31:0] v;
    wait_cyc(3);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset values
    rd(8'h00, v); check("R1 counter", v, 32'h0);
    rd(8'h04, v); check("R1 alarm0", v, 32'h0);
    rd(8'h18, v); check("R1 alarm1", v, 32'h0);
    rd(8'h08, v); check("R1 status", v, 32'h0);
    rd(8'h0C, v); check("R1 divider", v, 32'd1023);
    rd(8'h1C, v); check("R1 clksel", v, 32'h3);
    rd(8'h40, v); check("R1 scratch", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 wake", {31'b0, wake}, 32'h0);

    // R6 R12 register walk
    for (int i = 0; i < NV; i++) begin
      wr(V_ADDR[i], V_WR[i]);
      rd(V_ADDR[i], v);
      check($sformatf("R6 R12 walk offset %h", V_ADDR[i]), v, V_EXP[i]);
    end
    wait_cyc(2);
    check("R12 rdata holds", bus_rdata, V_EXP[NV-1]);

    // R8 reserved clock code stops counting (clksel=2, div=1)
    wr(8'h00, 32'd100);
    wait_cyc(8);
    rd(8'h00, v); check("R8 counter held", v, 32'd100);

    // R2 ten tick periods of 4 cycles
    wr(8'h1C, 32'h3);
    wait_cyc(40);
    rd(8'h00, v); check("R2 counter after 10 ticks", v, 32'd110);

    // R10 alarm written off the counter does not fire
    wr(8'h1C, 32'h0);
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h08, 32'h17);
    wr(8'h04, 32'h0);
    wait_cyc(2);
    rd(8'h08, v); check("R10 no spurious alarm0", v, 32'h04);
    check("R10 irq low", {31'b0, irq}, 32'h0);

    // R9 wrap then R3 alarm0 at zero
    wr(8'h1C, 32'h3);
    wait_cyc(4);
    rd(8'h00, v); check("R9 wrap to zero", v, 32'h0);
    wait_cyc(3);
    check("R3 R7 irq on alarm0", {31'b0, irq}, 32'h1);
    rd(8'h08, v); check("R3 R11 status after wrap", v, 32'h07);

    // R4 clear alarm0 flag, tick flag written 0 stays
    wr(8'h08, 32'h05);
    wait_cyc(2);
    check("R4 irq after clear", {31'b0, irq}, 32'h0);
    rd(8'h08, v); check("R4 R11 status after w1c", v, 32'h06);

    // R5 R7 tick enable gates irq
    wr(8'h08, 32'h0C);
    wait_cyc(2);
    check("R5 R7 irq via tick", {31'b0, irq}, 32'h1);
    check("R7 wake via tick", {31'b0, wake}, 32'h1);
    wr(8'h08, 32'h04);
    wait_cyc(2);
    check("R7 irq after enable drop", {31'b0, irq}, 32'h0);

    // R10 alarm1 = 0 against zero counter fires; enable gating
    wr(8'h1C, 32'h0);
    wr(8'h08, 32'h00);
    wr(8'h00, 32'h0);
    wr(8'h18, 32'h0);
    wait_cyc(2);
    rd(8'h08, v); check("R10 alarm1 fires at zero", v & 32'h10, 32'h10);
    check("R7 irq masked", {31'b0, irq}, 32'h0);
    wr(8'h08, 32'h40);
    wait_cyc(2);
    check("R7 irq alarm1 enabled", {31'b0, irq}, 32'h1);
    wr(8'h08, 32'h13);
    wait_cyc(3);
    check("R4 irq after full clear", {31'b0, irq}, 32'h0);
    rd(8'h08, v); check("R3 R4 no refire while equal", v, 32'h00);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule